// File: doc/BRIEF.md
# Serial NOR Flash Execute-in-Place Read Sequencer

This block makes a serial NOR flash readable as 32-bit words with as few serial clocks per word as possible. Coming out of reset, it brings the flash up in two chip-select frames. The first frame unlocks the flash for a register write. The second frame writes the volatile configuration register. That register write shortens the dummy phase, turns on continuous-read (execute-in-place) mode and selects the wrap setting. The block raises its busy flag for the whole bring-up.

After bring-up, a host pulses a read strobe with a word address and waits for busy to fall; the word is then on the read-data output and stays there until the next read completes. The first read sends the dual-I/O fast-read command byte, and during its dummy phase the block drives the pins low, which tells the flash to stay in continuous-read mode. Every later read skips the command byte and goes straight to the address, so it is eight serial clocks shorter. Address and dummy phases use both data pins. The data phase releases them so the flash can answer two bits per clock.

A strobe that arrives while the block is busy (bring-up or a read in progress) is held in a one-deep slot and served as soon as the block is idle. Any further strobe while that slot is full is dropped.

Top module: `xip_flash_seq`

## Requirements
- R1: After reset, chip select is high and busy is high; after one idle cycle the first frame is eight serial clocks carrying the unlock command 06h, most significant bit first, with the same bit on both data pins.
- R2: One idle cycle after the unlock frame, a sixteen-clock frame sends command 08h and then the configuration byte: the dummy-clock count in bits [7:4], a 1 in bit 3 (continuous-read enable), 0 in bit 2, 11 in bits [1:0]. With the default count of 4 the byte is 4Bh.
- R3: Chip select is high for at least one system clock between any two frames, and stays high whenever no frame is in progress.
- R4: Busy is high from reset until the configuration frame has ended, and during every read frame. A strobe seen while busy is held and served once the block is idle. A second strobe while one is held is ignored.
- R5: The first read after bring-up sends command BBh over eight clocks, one bit per clock mirrored on both pins, before the address.
- R6: The address phase lasts twelve clocks. It sends the 24-bit byte address {2'b00, word address, 2'b00}, most significant pair first, with pin 1 carrying the higher bit of each pair.
- R7: After the address comes a dummy phase, as many clocks as the configured count, with both pins driven low.
- R8: Every read after the first one starts directly with the address phase and sends no command byte.
- R9: The data phase lasts sixteen clocks with both pins released. The block captures pin 1 as the higher bit of each pair, takes the first byte received as the least significant byte, and reverses the byte order to form the word.
- R10: The serial clock equals the inverted system clock while chip select is low and is held low otherwise.
- R11: Busy falls in the cycle right after the last data clock. The read-data output then shows the new word and keeps it until the next read completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_stb | input | 1 | One-cycle request to read a word |
| rd_word_addr | input | 20 | Word address of the request |
| rd_data | output | 32 | Word returned by the most recent completed read |
| rd_busy | output | 1 | High during bring-up, reads and while a request is held |
| spi_sck | output | 1 | Serial clock to the flash |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_io_o | output | 2 | Values driven onto the two data pins |
| spi_io_oe | output | 1 | Output enable for both data pins |
| spi_io_i | input | 2 | Values read back from the two data pins |

## Verification
Reads are issued in four patterns. One strobe is held during bring-up while a second is dropped. One strobe is issued on the very first idle cycle after a frame. One strobe is issued in the middle of a running read and is deferred. The remaining strobes are issued far apart. Together these show the difference between holding, dropping and serving a request. Address values of all-zeros, all-ones and both alternating patterns show any mis-ordered or mis-shifted address pair. Pseudo-random flash contents show a wrong byte reversal or a wrong pin-to-bit mapping. Comparing the first read against the later ones shows whether the command byte is sent only once.

// File: rtl/xfs_pkg.sv
package xfs_pkg;

    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;

    localparam logic [7:0] CMD_UNLOCK  = 8'h06;
    localparam logic [7:0] CMD_CFG_WR  = 8'h08;
    localparam logic [7:0] CMD_DIO_RD  = 8'hBB;

    typedef enum logic [3:0] {
        ST_BOOT,
        ST_UNLOCK,
        ST_GAP,
        ST_CFG,
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_DUMMY,
        ST_DATA
    } xfs_state_e;

    function automatic logic in_frame(xfs_state_e s);
        return (s == ST_UNLOCK) || (s == ST_CFG) || (s == ST_CMD) ||
               (s == ST_ADDR) || (s == ST_DUMMY) || (s == ST_DATA);
    endfunction

endpackage

// File: rtl/xfs_ctrl.sv
module xfs_ctrl
    import xfs_pkg::*;
#(
    parameter int AW    = 20,
    parameter int DUMMY = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_stb,
    input  logic [AW-1:0]       rd_word_addr,
    input  logic [1:0]          pin_in,
    output xfs_state_e          state,
    output logic [1:0]          shift_top,
    output logic [WORD_W-1:0]   raw_word,
    output logic                busy
);

    localparam int ABITS   = AW + 4;
    localparam int ACLK    = ABITS / 2;
    localparam int SW      = (ABITS > 16) ? ABITS : 16;
    localparam int DCLK    = WORD_W / 2;
    localparam int MAXC    = (DCLK > ACLK) ? DCLK : ACLK;
    localparam int CW      = $clog2(MAXC + 1);
    localparam logic [7:0] CFG_BYTE = {4'(DUMMY), 1'b1, 1'b0, 2'b11};

    typedef struct packed {
        xfs_state_e           st;
        logic [CW-1:0]        cnt;
        logic [SW-1:0]        sh;
        logic [AW-1:0]        addr;
        logic                 pend;
        logic [AW-1:0]        paddr;
        logic                 xip;
        logic [WORD_W-3:0]    rx;
        logic [WORD_W-1:0]    word;
    } regs_t;

    localparam regs_t RST = '{st: ST_BOOT, default: '0};

    regs_t r_q, r_d;

    function automatic logic [SW-1:0] load_byte(logic [7:0] b);
        return SW'(b) << (SW - 8);
    endfunction

    function automatic logic [SW-1:0] load_addr(logic [AW-1:0] a);
        logic [ABITS-1:0] v;
        v = {2'b00, a, 2'b00};
        return SW'(v) << (SW - ABITS);
    endfunction

    always_comb begin
        logic done;
        logic [AW-1:0] sel;
        r_d  = r_q;
        done = (r_q.cnt == '0);
        sel  = r_q.pend ? r_q.paddr : rd_word_addr;
        if (!done) r_d.cnt = r_q.cnt - CW'(1);

        if (r_q.st != ST_IDLE && rd_stb && !r_q.pend) begin
            r_d.pend  = 1'b1;
            r_d.paddr = rd_word_addr;
        end

        case (r_q.st)
            ST_BOOT: begin
                r_d.st  = ST_UNLOCK;
                r_d.cnt = CW'(7);
                r_d.sh  = load_byte(CMD_UNLOCK);
            end
            ST_UNLOCK: begin
                r_d.sh = r_q.sh << 1;
                if (done) r_d.st = ST_GAP;
            end
            ST_GAP: begin
                r_d.st  = ST_CFG;
                r_d.cnt = CW'(15);
                r_d.sh  = SW'({CMD_CFG_WR, CFG_BYTE}) << (SW - 16);
            end
            ST_CFG: begin
                r_d.sh = r_q.sh << 1;
                if (done) r_d.st = ST_IDLE;
            end
            ST_IDLE: begin
                if (r_q.pend || rd_stb) begin
                    r_d.addr = sel;
                    if (r_q.pend) begin
                        r_d.pend = rd_stb;
                        if (rd_stb) r_d.paddr = rd_word_addr;
                    end
                    if (r_q.xip) begin
                        r_d.st  = ST_ADDR;
                        r_d.cnt = CW'(ACLK - 1);
                        r_d.sh  = load_addr(sel);
                    end else begin
                        r_d.st  = ST_CMD;
                        r_d.cnt = CW'(7);
                        r_d.sh  = load_byte(CMD_DIO_RD);
                    end
                end
            end
            ST_CMD: begin
                r_d.sh = r_q.sh << 1;
                if (done) begin
                    r_d.st  = ST_ADDR;
                    r_d.cnt = CW'(ACLK - 1);
                    r_d.sh  = load_addr(r_q.addr);
                end
            end
            ST_ADDR: begin
                r_d.sh = r_q.sh << 2;
                if (done) begin
                    r_d.st  = ST_DUMMY;
                    r_d.cnt = CW'(DUMMY - 1);
                    r_d.sh  = '0;
                end
            end
            ST_DUMMY: begin
                if (done) begin
                    r_d.st  = ST_DATA;
                    r_d.cnt = CW'(DCLK - 1);
                    r_d.xip = 1'b1;
                end
            end
            ST_DATA: begin
                r_d.rx = {r_q.rx[WORD_W-5:0], pin_in};
                if (done) begin
                    r_d.word = {r_q.rx, pin_in};
                    r_d.st   = ST_IDLE;
                end
            end
            default: r_d = RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RST;
        else        r_q <= r_d;
    end

    assign state     = r_q.st;
    assign shift_top = r_q.sh[SW-1 -: 2];
    assign raw_word  = r_q.word;
    assign busy      = (r_q.st != ST_IDLE) || r_q.pend;

endmodule

// File: rtl/xfs_pads.sv
module xfs_pads
    import xfs_pkg::*;
(
    input  logic        clk,
    input  xfs_state_e  state,
    input  logic [1:0]  shift_top,
    output logic        sck,
    output logic        cs_n,
    output logic        io_oe,
    output logic [1:0]  io_o
);

    logic selected;
    logic dual;

    always_comb begin
        selected = in_frame(state);
        dual     = (state == ST_ADDR) || (state == ST_DUMMY) || (state == ST_DATA);
        cs_n     = !selected;
        io_oe    = selected && (state != ST_DATA);
        io_o     = dual ? shift_top : {2{shift_top[1]}};
        sck      = selected && !clk;
    end

endmodule

// File: rtl/xfs_byte_rev.sv
module xfs_byte_rev #(
    parameter int NBYTES = 4,
    parameter int BW     = 8
) (
    input  logic [NBYTES*BW-1:0] din,
    output logic [NBYTES*BW-1:0] dout
);

    for (genvar i = 0; i < NBYTES; i++) begin : g_lane
        assign dout[i*BW +: BW] = din[(NBYTES-1-i)*BW +: BW];
    end

endmodule

// File: rtl/xip_flash_seq.sv
module xip_flash_seq
    import xfs_pkg::*;
#(
    parameter int AW    = 20,
    parameter int DUMMY = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic [AW-1:0]     rd_word_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_busy,
    output logic              spi_sck,
    output logic              spi_cs_n,
    output logic [1:0]        spi_io_o,
    output logic              spi_io_oe,
    input  logic [1:0]        spi_io_i
);

    xfs_state_e        st;
    logic [1:0]        top2;
    logic [WORD_W-1:0] raw;

    xfs_ctrl #(.AW(AW), .DUMMY(DUMMY)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_stb       (rd_stb),
        .rd_word_addr (rd_word_addr),
        .pin_in       (spi_io_i),
        .state        (st),
        .shift_top    (top2),
        .raw_word     (raw),
        .busy         (rd_busy)
    );

    xfs_pads u_pads (
        .clk       (clk),
        .state     (st),
        .shift_top (top2),
        .sck       (spi_sck),
        .cs_n      (spi_cs_n),
        .io_oe     (spi_io_oe),
        .io_o      (spi_io_o)
    );

    xfs_byte_rev #(.NBYTES(WORD_W / BYTE_W), .BW(BYTE_W)) u_rev (
        .din  (raw),
        .dout (rd_data)
    );

endmodule

// File: rtl/xfs_checker.sv
module xfs_checker #(
    parameter int DUMMY = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        rd_busy,
    input logic [31:0] rd_data,
    input logic        spi_sck,
    input logic        spi_cs_n,
    input logic        spi_io_oe
);

    localparam int BOOT_CYC = 1 + 8 + 1 + 16;
    localparam int CNT_W    = $clog2(BOOT_CYC + 1);

    logic [CNT_W-1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        since_rst <= '0;
        else if (since_rst != CNT_W'(BOOT_CYC)) since_rst <= since_rst + CNT_W'(1);
    end

    p_busy_bootup_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < CNT_W'(BOOT_CYC)) |-> rd_busy);

    p_busy_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n |-> rd_busy);

    p_sck_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sck == !spi_cs_n);

    p_drive_needs_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        spi_io_oe |-> !spi_cs_n);

    p_release_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_io_oe && !spi_cs_n) |=> (!spi_io_oe || spi_cs_n));

    p_word_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(spi_cs_n) && spi_cs_n) |-> $stable(rd_data));

endmodule

bind xip_flash_seq xfs_checker #(.DUMMY(DUMMY)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_busy   (rd_busy),
    .rd_data   (rd_data),
    .spi_sck   (spi_sck),
    .spi_cs_n  (spi_cs_n),
    .spi_io_oe (spi_io_oe)
);

// File: tb/xip_flash_seq_tb.sv
`timescale 1ns/1ps
module xip_flash_seq_tb;

    localparam int AW    = 20;
    localparam int DUMMY = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_stb = 1'b0;
    logic [19:0] rd_word_addr = '0;
    logic [31:0] rd_data;
    logic        rd_busy;
    logic        spi_sck, spi_cs_n, spi_io_oe;
    logic [1:0]  spi_io_o;
    logic [1:0]  spi_io_i = 2'b01;

    always #4 clk = ~clk;

    xip_flash_seq #(.AW(AW), .DUMMY(DUMMY)) u_dut (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_word_addr(rd_word_addr),
        .rd_data(rd_data), .rd_busy(rd_busy), .spi_sck(spi_sck),
        .spi_cs_n(spi_cs_n), .spi_io_o(spi_io_o), .spi_io_oe(spi_io_oe),
        .spi_io_i(spi_io_i)
    );

    typedef struct {
        bit       sel;
        bit       oe;
        bit [1:0] io;
        int       didx;
        string    tag;
    } rec_t;

    rec_t        q[$];
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          m_pend = 0;
    bit [19:0]   m_paddr = '0;
    bit          m_xip = 0;
    bit [19:0]   cur_a = '0;
    bit [31:0]   last_word = '0;
    bit          done_flag = 0;

    function automatic bit [31:0] flash_word(bit [19:0] a);
        return ({12'h0, a} * 32'h9E3779B1) ^ 32'h5A5A0F0F;
    endfunction

    function automatic bit [1:0] flash_pair(bit [19:0] a, int j);
        bit [31:0] w;
        bit [7:0]  b;
        w = flash_word(a);
        b = w[8*(j/4) +: 8];
        return b[7-2*(j%4) -: 2];
    endfunction

    task automatic push(bit sel, bit oe, bit [1:0] io, int d, string tag);
        rec_t r;
        r.sel = sel; r.oe = oe; r.io = io; r.didx = d; r.tag = tag;
        q.push_back(r);
    endtask

    task automatic push_byte(bit [7:0] b, string tag);
        for (int i = 7; i >= 0; i--) push(1, 1, {2{b[i]}}, -1, tag);
    endtask

    task automatic start_read(bit [19:0] a);
        bit [23:0] av;
        av = {2'b00, a, 2'b00};
        if (!m_xip) push_byte(8'hBB, "R5");
        for (int k = 0; k < 12; k++) push(1, 1, av[23-2*k -: 2], -1, m_xip ? "R8 R6" : "R6");
        for (int k = 0; k < DUMMY; k++) push(1, 1, 2'b00, -1, "R7");
        for (int j = 0; j < 16; j++) push(1, 0, 2'b00, j, "R9");
        m_xip = 1;
        cur_a = a;
    endtask

    task automatic model_step(bit stb, bit [19:0] a);
        bit was_idle;
        rec_t r;
        was_idle = (q.size() == 0);
        if (!was_idle) begin
            r = q.pop_front();
            if (r.didx == 15) last_word = flash_word(cur_a);
            if (stb && !m_pend) begin m_pend = 1; m_paddr = a; end
        end else if (m_pend) begin
            start_read(m_paddr);
            m_pend = stb;
            if (stb) m_paddr = a;
        end else if (stb) begin
            start_read(a);
        end
    endtask

    task automatic chk(bit ok, string tag, string what, bit [31:0] act, bit [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        bit    e_sel, e_oe;
        string t;
        e_sel = (q.size() != 0) && q[0].sel;
        e_oe  = (q.size() != 0) && q[0].oe;
        t     = (q.size() != 0) ? q[0].tag : "R3";
        chk(spi_cs_n == !e_sel, t, "cs_n", {31'b0, spi_cs_n}, {31'b0, !e_sel});
        chk(spi_io_oe == e_oe, t, "io_oe", {31'b0, spi_io_oe}, {31'b0, e_oe});
        if (e_oe) chk(spi_io_o == q[0].io, t, "io_o", {30'b0, spi_io_o}, {30'b0, q[0].io});
        chk(spi_sck == e_sel, "R10", "sck", {31'b0, spi_sck}, {31'b0, e_sel});
        chk(rd_busy == ((q.size() != 0) || m_pend), "R4 R11", "busy",
            {31'b0, rd_busy}, {31'b0, (q.size() != 0) || m_pend});
        chk(rd_data == last_word, "R9 R11", "rd_data", rd_data, last_word);
    endtask

    task automatic cyc(bit stb, bit [19:0] a);
        rd_stb = stb;
        rd_word_addr = a;
        @(posedge clk);
        model_step(stb, a);
        @(negedge clk);
        #1;
        rd_stb = 1'b0;
        compare();
        if (q.size() != 0 && q[0].didx >= 0) spi_io_i = flash_pair(cur_a, q[0].didx);
        else                                 spi_io_i = 2'b10;
    endtask

    task automatic wait_idle();
        while (q.size() != 0 || m_pend) cyc(0, '0);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        chk(spi_cs_n == 1'b1, "R1", "reset cs_n", {31'b0, spi_cs_n}, 32'd1);
        chk(rd_busy == 1'b1, "R1", "reset busy", {31'b0, rd_busy}, 32'd1);
        chk(spi_io_oe == 1'b0, "R1", "reset oe", {31'b0, spi_io_oe}, 32'd0);
        rst_n = 1'b1;
        push(0, 0, 2'b00, -1, "R3");
        push_byte(8'h06, "R1");
        push(0, 0, 2'b00, -1, "R3");
        push_byte(8'h08, "R2");
        push_byte({4'(DUMMY), 1'b1, 1'b0, 2'b11}, "R2");

        // R4: strobe held during bring-up, a second one dropped
        cyc(0, '0); cyc(0, '0); cyc(0, '0);
        cyc(1, 20'h12345);
        cyc(1, 20'hABCDE);
        wait_idle();
        // R8: immediate strobe on the first idle cycle, continuous-read path
        cyc(1, 20'hFFFFF);
        repeat (10) cyc(0, '0);
        // R4: strobe during a read is deferred
        cyc(1, 20'h00000);
        wait_idle();
        repeat (3) cyc(0, '0);
        cyc(1, 20'h55555);
        wait_idle();
        repeat (5) cyc(0, '0);
        cyc(1, 20'hAAAAA);
        wait_idle();
        // R11: word held while idle
        repeat (6) cyc(0, '0);
        finish_run();
    end

endmodule